// File: doc/BRIEF.md
# Performance monitor counter unit

This block holds a small set of performance counters behind a single-cycle register port: one 64-bit cycle counter and a parameterised number of 32-bit event counters. The only event source is a software increment. Software writes that register with one bit per event counter, and every selected counter that is allowed to count steps by one. The cycle counter advances on every clock while it is enabled. Counting depends on a global enable, on a per-counter enable, and on a privilege filter checked against the current privilege input.

The counter enables and the interrupt enables each live in one state register that can be reached through two addresses: a set alias that ORs bits in and a clear alias that removes them. Overflow flags are sticky and are cleared by writing 1 to them. The single interrupt output combines the interrupt enables, the overflow flags and the global enable. A select register gives a second way to reach a counter's type register, and one select value reaches the cycle counter's filter.

Top module: `perfmon_unit`

## Requirements
- R1: After a synchronous reset, all state is zero and `irq` is low. Reading the control word (address 0) returns only the read-only counter-count field in bits 15:11, which holds NUM_EVT.
- R2: Writing the control word (address 0) updates only bits 0 (global enable) and 6:3, and all other stored bits keep their value. Bits 1 and 2 are action bits that read back as 0, and bits 15:11 read NUM_EVT.
- R3: A control write with bit 2 set clears the 64-bit cycle counter. A control write with bit 1 set clears every event counter.
- R4: The counter-enable state has bit 31 for the cycle counter and bits NUM_EVT-1:0 for the event counters. Writing address 1 ORs in the written bits, and writing address 2 clears the written bits, both limited to the implemented bits. Both addresses read the same state.
- R5: The interrupt-enable state covers bits NUM_EVT-1:0. Address 3 sets bits, address 4 clears bits, and both addresses read the state.
- R6: The overflow flags (address 5) are cleared by writing 1 to them. Bits written as 0 are unchanged, and reads return the flags.
- R7: `irq` is high exactly when control bit 0 is set and some bit is set in both the interrupt-enable state and the overflow flags.
- R8: The cycle counter increments once per clock when control bit 0 and enable bit 31 are both set and the counter is not filtered. The filter word is at address 9: bit 31 blocks counting at user level (`priv_kernel`=0) and bit 30 blocks counting at kernel level. Address 10 writes the low half and address 11 writes the high half, and a carry moves from the low half into the high half.
- R9: A write to address 6 increments event counter i (read and written at address 16+i) for each set bit i, but only when control bit 0 and enable bit i are set and the counter's type word (address 32+i) is not filtered. That type word uses bit 31 for the user filter and bit 30 for the kernel filter. Bits beyond the implemented counters are ignored.
- R10: When a software increment takes bit 31 of an event counter from 1 to 0, overflow flag i is set. Flags stay set until they are cleared.
- R11: The select register (address 7) keeps only its low 5 bits, and the user-enable register (address 8) keeps only its low 4 bits. Address 14 reaches the type word of the selected counter, and a select value of 31 reaches the cycle filter. Stored type words keep bits 31:30 and 9:0, and the stored cycle filter keeps bits 31:30.
- R12: Addresses 12 and 13 (event-ID words) read as zero. An event counter whose type bits 9:0 hold any value other than 0 (software increment) never counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv_kernel | input | 1 | Current privilege: 1 kernel, 0 user |
| reg_addr | input | 6 | Register word address |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| irq | output | 1 | Overflow interrupt request |

## Verification
Reads are combinational, so a read result is due in the same cycle the address is presented. A write takes effect at the edge that follows the cycle in which it is driven. The bench therefore drives every input one time unit after a rising edge, and the scoreboard monitor compares each queued expectation at the falling edge of that same cycle. The cycle counter steps at every edge whose pre-edge state enables it, so a start write, n idle cycles and a stop write give exactly n+1 counts, and the expected values are built from that rule. The interrupt output follows the registered state without a further delay, so it is checked in the cycle just after the write that changes a flag, an enable or the global enable.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;
  localparam int DW     = 32;
  localparam int REG_AW = 6;
  localparam int SEL_W  = 5;
  localparam int UEN_W  = 4;
  localparam int EVN_W  = 10;

  localparam logic [REG_AW-1:0] A_CTRL    = 6'd0;
  localparam logic [REG_AW-1:0] A_ENSET   = 6'd1;
  localparam logic [REG_AW-1:0] A_ENCLR   = 6'd2;
  localparam logic [REG_AW-1:0] A_IESET   = 6'd3;
  localparam logic [REG_AW-1:0] A_IECLR   = 6'd4;
  localparam logic [REG_AW-1:0] A_OVF     = 6'd5;
  localparam logic [REG_AW-1:0] A_SWINC   = 6'd6;
  localparam logic [REG_AW-1:0] A_SEL     = 6'd7;
  localparam logic [REG_AW-1:0] A_UEN     = 6'd8;
  localparam logic [REG_AW-1:0] A_CFILT   = 6'd9;
  localparam logic [REG_AW-1:0] A_CYCLO   = 6'd10;
  localparam logic [REG_AW-1:0] A_CYCHI   = 6'd11;
  localparam logic [REG_AW-1:0] A_EVID0   = 6'd12;
  localparam logic [REG_AW-1:0] A_EVID1   = 6'd13;
  localparam logic [REG_AW-1:0] A_SELTYPE = 6'd14;
  localparam logic [REG_AW-1:0] A_EVCNT_BASE  = 6'd16;
  localparam logic [REG_AW-1:0] A_EVTYPE_BASE = 6'd32;

  localparam int CTRL_EN       = 0;
  localparam int CTRL_EVRST    = 1;
  localparam int CTRL_CYRST    = 2;
  localparam int CTRL_NUM_LSB  = 11;
  localparam logic [DW-1:0] CTRL_WMASK = 32'h0000_0079;

  localparam int FLT_U   = 31;
  localparam int FLT_P   = 30;
  localparam int CYC_IDX = 31;
  localparam logic [DW-1:0]    TYPE_MASK  = 32'hC000_03FF;
  localparam logic [DW-1:0]    CFILT_MASK = 32'hC000_0000;
  localparam logic [EVN_W-1:0] EV_SWINC   = 10'h000;

  // Privilege filter: user level honours bit 31, kernel level bit 30.
  function automatic logic filtered(input logic [DW-1:0] flt, input logic kern);
    return kern ? flt[FLT_P] : flt[FLT_U];
  endfunction
endpackage

// File: rtl/perfmon_evcnt.sv
module perfmon_evcnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         wr,
  input  logic         inc,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] count,
  output logic         ovf
);
  logic [W-1:0] nxt;

  assign nxt = count + W'(1);
  // Top bit falling from 1 to 0 on a step marks a wrap.
  assign ovf = inc && count[W-1] && !nxt[W-1];

  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (wr)    count <= wdata;
    else if (inc)   count <= nxt;
  end

  // R10: a wrap can only come from the all-ones value
  a_r10_wrap_from_ones: assert property (@(posedge clk) disable iff (rst)
    ovf |-> (count == '1));

  // R9: a qualified increment advances the count by exactly one
  a_r9_single_step: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr && !wr) |=> (count == $past(count) + W'(1)));
endmodule

// File: rtl/perfmon_cyccnt.sv
module perfmon_cyccnt #(
  parameter int HW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            run,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [HW-1:0]   wdata,
  output logic [2*HW-1:0] count
);
  localparam int W = 2 * HW;

  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (wr_lo) count[HW-1:0] <= wdata;
    else if (wr_hi) count[W-1:HW] <= wdata;
    else if (run)   count <= count + W'(1);
  end

  // R8: no enabled tick and no write means the value holds
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!run && !clr && !wr_lo && !wr_hi) |=> $stable(count));

  // R8: an enabled tick adds one across both halves
  a_r8_tick: assert property (@(posedge clk) disable iff (rst)
    (run && !clr && !wr_lo && !wr_hi) |=> (count == $past(count) + W'(1)));
endmodule

// File: rtl/perfmon_unit.sv
module perfmon_unit
  import perfmon_pkg::*;
#(
  parameter int NUM_EVT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              priv_kernel,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq
);
  localparam logic [DW-1:0] EN_MASK =
    (DW'(1) << CYC_IDX) | ((DW'(1) << NUM_EVT) - DW'(1));

  // register state
  logic [DW-1:0]      ctrl_q, en_q, cflt_q;
  logic [NUM_EVT-1:0] ie_q, ovf_q, ovf_hit, inc;
  logic [SEL_W-1:0]   sel_q;
  logic [UEN_W-1:0]   uen_q;
  logic [DW-1:0]      ev_cnt  [NUM_EVT];
  logic [DW-1:0]      ev_type [NUM_EVT];
  logic [2*DW-1:0]    cyc_cnt;

  // write decode
  logic wr_ctrl, wr_enset, wr_enclr, wr_ieset, wr_ieclr, wr_ovf, wr_swinc;
  logic wr_sel, wr_uen, wr_cflt_dir, wr_seltype, wr_cyclo, wr_cychi, wr_cflt;
  logic sel_is_cyc, gl_en, ev_rst, cyc_rst, cyc_run;

  assign wr_ctrl     = reg_we && (reg_addr == A_CTRL);
  assign wr_enset    = reg_we && (reg_addr == A_ENSET);
  assign wr_enclr    = reg_we && (reg_addr == A_ENCLR);
  assign wr_ieset    = reg_we && (reg_addr == A_IESET);
  assign wr_ieclr    = reg_we && (reg_addr == A_IECLR);
  assign wr_ovf      = reg_we && (reg_addr == A_OVF);
  assign wr_swinc    = reg_we && (reg_addr == A_SWINC);
  assign wr_sel      = reg_we && (reg_addr == A_SEL);
  assign wr_uen      = reg_we && (reg_addr == A_UEN);
  assign wr_cflt_dir = reg_we && (reg_addr == A_CFILT);
  assign wr_seltype  = reg_we && (reg_addr == A_SELTYPE);
  assign wr_cyclo    = reg_we && (reg_addr == A_CYCLO);
  assign wr_cychi    = reg_we && (reg_addr == A_CYCHI);

  assign sel_is_cyc = (sel_q == SEL_W'(CYC_IDX));
  assign wr_cflt    = wr_cflt_dir || (wr_seltype && sel_is_cyc);
  assign gl_en      = ctrl_q[CTRL_EN];
  assign ev_rst     = wr_ctrl && reg_wdata[CTRL_EVRST];
  assign cyc_rst    = wr_ctrl && reg_wdata[CTRL_CYRST];
  assign cyc_run    = gl_en && en_q[CYC_IDX] && !filtered(cflt_q, priv_kernel);

  // control, enables, select and filter registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      en_q   <= '0;
      ie_q   <= '0;
      ovf_q  <= '0;
      sel_q  <= '0;
      uen_q  <= '0;
      cflt_q <= '0;
    end else begin
      if (wr_ctrl)  ctrl_q <= (ctrl_q & ~CTRL_WMASK) | (reg_wdata & CTRL_WMASK);
      if (wr_enset) en_q   <= en_q | (reg_wdata & EN_MASK);
      if (wr_enclr) en_q   <= en_q & ~(reg_wdata & EN_MASK);
      if (wr_ieset) ie_q   <= ie_q | reg_wdata[NUM_EVT-1:0];
      if (wr_ieclr) ie_q   <= ie_q & ~reg_wdata[NUM_EVT-1:0];
      ovf_q <= (ovf_q & ~(wr_ovf ? reg_wdata[NUM_EVT-1:0] : '0)) | ovf_hit;
      if (wr_sel)   sel_q  <= reg_wdata[SEL_W-1:0];
      if (wr_uen)   uen_q  <= reg_wdata[UEN_W-1:0];
      if (wr_cflt)  cflt_q <= reg_wdata & CFILT_MASK;
    end
  end

  // event counter slices
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    logic [DW-1:0] type_q;
    logic          wr_type, wr_cnt;

    assign wr_type = (reg_we && (reg_addr == A_EVTYPE_BASE + REG_AW'(i))) ||
                     (wr_seltype && (sel_q == SEL_W'(i)));
    assign wr_cnt  = reg_we && (reg_addr == A_EVCNT_BASE + REG_AW'(i));

    always_ff @(posedge clk) begin
      if (rst)          type_q <= '0;
      else if (wr_type) type_q <= reg_wdata & TYPE_MASK;
    end

    assign ev_type[i] = type_q;
    assign inc[i] = wr_swinc && reg_wdata[i] && gl_en && en_q[i] &&
                    !filtered(type_q, priv_kernel) &&
                    (type_q[EVN_W-1:0] == EV_SWINC);

    perfmon_evcnt #(.W(DW)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .clr   (ev_rst),
      .wr    (wr_cnt),
      .inc   (inc[i]),
      .wdata (reg_wdata),
      .count (ev_cnt[i]),
      .ovf   (ovf_hit[i])
    );
  end

  perfmon_cyccnt #(.HW(DW)) u_cyc (
    .clk   (clk),
    .rst   (rst),
    .clr   (cyc_rst),
    .run   (cyc_run),
    .wr_lo (wr_cyclo),
    .wr_hi (wr_cychi),
    .wdata (reg_wdata),
    .count (cyc_cnt)
  );

  // read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:           reg_rdata = ctrl_q | (DW'(NUM_EVT) << CTRL_NUM_LSB);
      A_ENSET, A_ENCLR: reg_rdata = en_q;
      A_IESET, A_IECLR: reg_rdata = DW'(ie_q);
      A_OVF:            reg_rdata = DW'(ovf_q);
      A_SEL:            reg_rdata = DW'(sel_q);
      A_UEN:            reg_rdata = DW'(uen_q);
      A_CFILT:          reg_rdata = cflt_q;
      A_CYCLO:          reg_rdata = cyc_cnt[DW-1:0];
      A_CYCHI:          reg_rdata = cyc_cnt[2*DW-1:DW];
      A_SELTYPE: begin
        if (sel_is_cyc) reg_rdata = cflt_q;
        else
          for (int i = 0; i < NUM_EVT; i++)
            if (sel_q == SEL_W'(i)) reg_rdata = ev_type[i];
      end
      default: begin
        for (int i = 0; i < NUM_EVT; i++) begin
          if (reg_addr == A_EVCNT_BASE + REG_AW'(i))  reg_rdata = ev_cnt[i];
          if (reg_addr == A_EVTYPE_BASE + REG_AW'(i)) reg_rdata = ev_type[i];
        end
      end
    endcase
  end

  assign irq = gl_en && |(ie_q & ovf_q);

  // R4: the set alias leaves every written implemented bit set
  a_r4_set_alias: assert property (@(posedge clk) disable iff (rst)
    wr_enset |=> ((en_q & $past(reg_wdata & EN_MASK)) == $past(reg_wdata & EN_MASK)));

  // R4: the clear alias removes every written implemented bit
  a_r4_clr_alias: assert property (@(posedge clk) disable iff (rst)
    wr_enclr |=> ((en_q & $past(reg_wdata & EN_MASK)) == '0));

  // R5: interrupt-enable clear alias
  a_r5_ie_clear: assert property (@(posedge clk) disable iff (rst)
    wr_ieclr |=> ((ie_q & $past(reg_wdata[NUM_EVT-1:0])) == '0));

  // R6: flags written as one are gone after the write
  a_r6_w1c: assert property (@(posedge clk) disable iff (rst)
    wr_ovf |=> ((ovf_q & $past(reg_wdata[NUM_EVT-1:0])) == '0));

  // R10: without a clearing write no flag drops
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    !wr_ovf |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q)));

  // R7: a low global enable silences the interrupt
  a_r7_irq_gated: assert property (@(posedge clk) disable iff (rst)
    !gl_en |-> !irq);

  // R11: select keeps the low five written bits
  a_r11_sel_keep: assert property (@(posedge clk) disable iff (rst)
    wr_sel |=> (sel_q == $past(reg_wdata[SEL_W-1:0])));
endmodule

// File: tb/sim_perfmon_unit.sv
module sim_perfmon_unit;
  import perfmon_pkg::*;

  localparam int NEV = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              priv_kernel = 1'b1;
  logic              we = 1'b0;
  logic [REG_AW-1:0] addr = '0;
  logic [DW-1:0]     wdata = '0;
  logic [DW-1:0]     rdata;
  logic              irq;

  always #4 clk = ~clk;  // 125 MHz

  perfmon_unit #(.NUM_EVT(NEV)) u0 (
    .clk         (clk),
    .rst         (rst),
    .priv_kernel (priv_kernel),
    .reg_addr    (addr),
    .reg_we      (we),
    .reg_wdata   (wdata),
    .reg_rdata   (rdata),
    .irq         (irq)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [DW-1:0] exp_q[$];
  bit            kind_q[$];
  string         tag_q[$];

  // driver tasks: inputs change one unit after a rising edge
  task automatic wr(input logic [REG_AW-1:0] a, input logic [DW-1:0] d);
    @(posedge clk); #1;
    we = 1'b1; addr = a; wdata = d;
  endtask

  task automatic idle();
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rd(input logic [REG_AW-1:0] a, input logic [DW-1:0] e, input string t);
    @(posedge clk); #1;
    we = 1'b0; addr = a;
    exp_q.push_back(e); kind_q.push_back(1'b0); tag_q.push_back(t);
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(posedge clk); #1;
    we = 1'b0;
    exp_q.push_back({{(DW-1){1'b0}}, e}); kind_q.push_back(1'b1); tag_q.push_back(t);
  endtask

  // monitor: compares at the falling edge of the cycle the item was queued
  always @(negedge clk) begin
    logic [DW-1:0] e, act;
    bit            k;
    string         t;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      k = kind_q.pop_front();
      t = tag_q.pop_front();
      act = k ? {{(DW-1){1'b0}}, irq} : rdata;
      checks++;
      if (act !== e) begin
        errors++;
        $display("FAIL %s: got %h expected %h", t, act, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    rd(A_CTRL, 32'h0000_2000, "R1 ctrl");
    rd(A_ENSET, 32'h0, "R1 enables");
    rd(A_OVF, 32'h0, "R1 overflow");
    rd(A_CYCLO, 32'h0, "R1 cycle");
    chk_irq(1'b0, "R1 irq");

    // R2 control mask
    wr(A_CTRL, 32'hFFFF_FFF9);
    rd(A_CTRL, 32'h0000_2079, "R2 masked write");
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, 32'h0000_2000, "R2 cleared");

    // R4 enable aliases
    wr(A_ENSET, 32'hFFFF_FFFF);
    rd(A_ENSET, 32'h8000_000F, "R4 set alias");
    rd(A_ENCLR, 32'h8000_000F, "R4 clear alias read");
    wr(A_ENCLR, 32'h8000_0001);
    rd(A_ENSET, 32'h0000_000E, "R4 clear");

    // R5 interrupt enable aliases
    wr(A_IESET, 32'h0000_00FF);
    rd(A_IESET, 32'h0000_000F, "R5 set");
    wr(A_IECLR, 32'h0000_0002);
    rd(A_IECLR, 32'h0000_000D, "R5 clear");

    // R11 select, user enable, selected type
    wr(A_SEL, 32'hFFFF_FFFF);
    rd(A_SEL, 32'h0000_001F, "R11 select width");
    wr(A_UEN, 32'hFFFF_FFFF);
    rd(A_UEN, 32'h0000_000F, "R11 user enable width");
    wr(A_SELTYPE, 32'hFFFF_FFFF);
    rd(A_CFILT, 32'hC000_0000, "R11 select 31 reaches filter");
    rd(A_SELTYPE, 32'hC000_0000, "R11 selected read");
    wr(A_SEL, 32'd2);
    wr(A_SELTYPE, 32'h4000_0003);
    rd(A_EVTYPE_BASE + 6'd2, 32'h4000_0003, "R11 selected type");

    // R12 event ids
    rd(A_EVID0, 32'h0, "R12 id0");
    rd(A_EVID1, 32'h0, "R12 id1");

    // R9 software increment
    wr(A_CTRL, 32'h1);
    wr(A_ENSET, 32'hF);
    wr(A_EVTYPE_BASE + 6'd0, 32'h0);
    wr(A_EVTYPE_BASE + 6'd1, 32'h8000_0000);
    wr(A_EVTYPE_BASE + 6'd3, 32'h0);
    priv_kernel = 1'b1;
    wr(A_SWINC, 32'hFFFF_FFFF);
    rd(A_EVCNT_BASE + 6'd0, 32'd1, "R9 cnt0 kernel");
    rd(A_EVCNT_BASE + 6'd1, 32'd1, "R9 cnt1 kernel");
    rd(A_EVCNT_BASE + 6'd2, 32'd0, "R12 non-swinc event");
    rd(A_EVCNT_BASE + 6'd3, 32'd1, "R9 cnt3 kernel");
    priv_kernel = 1'b0;
    wr(A_SWINC, 32'hF);
    rd(A_EVCNT_BASE + 6'd0, 32'd2, "R9 cnt0 user");
    rd(A_EVCNT_BASE + 6'd1, 32'd1, "R9 user filter");
    rd(A_EVCNT_BASE + 6'd3, 32'd2, "R9 cnt3 user");
    wr(A_ENCLR, 32'h8);
    wr(A_SWINC, 32'h8);
    rd(A_EVCNT_BASE + 6'd3, 32'd2, "R9 disabled counter");
    wr(A_CTRL, 32'h0);
    wr(A_SWINC, 32'h1);
    rd(A_EVCNT_BASE + 6'd0, 32'd2, "R9 global disable");
    wr(A_CTRL, 32'h1);

    // R10 overflow, R7 interrupt
    wr(A_EVCNT_BASE + 6'd0, 32'hFFFF_FFFF);
    rd(A_EVCNT_BASE + 6'd0, 32'hFFFF_FFFF, "R9 direct write");
    chk_irq(1'b0, "R7 before overflow");
    wr(A_SWINC, 32'h1);
    rd(A_EVCNT_BASE + 6'd0, 32'h0, "R10 wrap");
    rd(A_OVF, 32'h1, "R10 flag set");
    chk_irq(1'b1, "R7 raised");
    wr(A_CTRL, 32'h0);
    chk_irq(1'b0, "R7 global off");
    wr(A_CTRL, 32'h1);
    chk_irq(1'b1, "R7 global on");
    wr(A_IECLR, 32'h1);
    chk_irq(1'b0, "R7 enable off");
    wr(A_IESET, 32'h1);
    wr(A_EVCNT_BASE + 6'd3, 32'h7FFF_FFFF);
    wr(A_ENSET, 32'h8);
    wr(A_SWINC, 32'h8);
    rd(A_EVCNT_BASE + 6'd3, 32'h8000_0000, "R10 no wrap 0 to 1");
    rd(A_OVF, 32'h1, "R10 no new flag");

    // R6 write one to clear
    wr(A_OVF, 32'h0);
    rd(A_OVF, 32'h1, "R6 zero write");
    wr(A_OVF, 32'hFFFF_FFFE);
    rd(A_OVF, 32'h1, "R6 other bits");
    wr(A_OVF, 32'h1);
    rd(A_OVF, 32'h0, "R6 cleared");
    chk_irq(1'b0, "R7 after clear");

    // R3 event reset
    wr(A_CTRL, 32'h3);
    rd(A_EVCNT_BASE + 6'd3, 32'h0, "R3 event reset cnt3");
    rd(A_EVCNT_BASE + 6'd1, 32'h0, "R3 event reset cnt1");
    rd(A_CTRL, 32'h0000_2001, "R2 action bits read 0");

    // R8 cycle counter
    wr(A_ENCLR, 32'h8000_0000);
    wr(A_CFILT, 32'h0);
    wr(A_CTRL, 32'h5);
    rd(A_CYCLO, 32'h0, "R3 cycle reset lo");
    wr(A_ENSET, 32'h8000_0000);
    idle(); idle(); idle();
    wr(A_ENCLR, 32'h8000_0000);
    rd(A_CYCLO, 32'd4, "R8 run window");
    wr(A_CFILT, 32'h8000_0000);
    wr(A_ENSET, 32'h8000_0000);
    idle(); idle(); idle();
    wr(A_ENCLR, 32'h8000_0000);
    rd(A_CYCLO, 32'd4, "R8 user filtered");
    priv_kernel = 1'b1;
    wr(A_ENSET, 32'h8000_0000);
    idle(); idle();
    wr(A_ENCLR, 32'h8000_0000);
    rd(A_CYCLO, 32'd7, "R8 kernel not filtered");
    wr(A_CYCHI, 32'h12);
    rd(A_CYCHI, 32'h12, "R8 high write");
    rd(A_CYCLO, 32'd7, "R8 low kept");
    wr(A_CYCLO, 32'hFFFF_FFFF);
    wr(A_ENSET, 32'h8000_0000);
    wr(A_ENCLR, 32'h8000_0000);
    rd(A_CYCLO, 32'h0, "R8 carry low");
    rd(A_CYCHI, 32'h13, "R8 carry high");
    wr(A_CTRL, 32'h5);
    rd(A_CYCLO, 32'h0, "R3 cycle reset lo");
    rd(A_CYCHI, 32'h0, "R3 cycle reset hi");

    idle(); idle();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule